// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power-saving state a small microcontroller system enters, holds it there, and brings it back out. When the core issues a sleep request, the block looks at a handful of independent configuration bits and settles on one of four states. In sleep, only the core clock is gated. In wait, the core clock is off and the flash goes to standby or deep power-down. In backup, the core regulator is switched off. Combinations of bits that match none of these are refused and the core keeps running.

Each state has its own set of events that may end it. Sleep ends on a pending enabled interrupt. Either wait variant ends on an enabled wake pin, an RTC or RTT alarm, a high-speed USB event, a debug power-up request or a network wake packet. Backup ends on an enabled wake pin, the supply monitor, or an RTC or RTT alarm. Leaving wait runs a fixed restart window and then turns the clock back on, running from the internal RC source. Leaving backup asserts a core reset for a fixed window. A status pair records the last state entered and the event that ended a state.

Top module: `lpm_sequencer`

## Requirements
- R1: A request with the regulator-off bit and the deep-sleep bit both 1 enters backup. From the next cycle core_reg_en is 0, core_clk_en is 0 and flash_pwr is 3 (off).
- R2: A request with deep-sleep 0, low-power 1, wait-enable 1 and a divider field of 0 enters wait. flash_pwr is 2 (deep power-down) when the flash-low-power bit is 1 and 1 (standby) when it is 0. cur_mode is then 3 or 2 respectively.
- R3: A request with deep-sleep 0 and low-power 0 enters sleep. From the next cycle core_clk_en is 0, core_reg_en is 1 and cur_mode is 1. In run, cur_mode is 0.
- R4: A request matching none of the three patterns above is ignored. Examples are deep-sleep 1 with regulator-off 0, or low-power 1 with wait-enable 0 or a nonzero divider. core_clk_en stays 1 and cur_mode stays 0.
- R5: In backup, an enabled pin, the supply monitor, or an RTC or RTT alarm sets core_rst_req to 1 on the next cycle for BKUP_RST_CYC cycles, after which the core runs. Interrupts, USB, debug and network events are ignored in backup.
- R6: In wait, an enabled pin, RTC, RTT, USB, debug or network event is followed by exactly WAIT_WAKE_CYC cycles with the clock still off and no reset, and then core_clk_en is 1. At that point clk_on_rc is 1, and it clears on the next accepted request. The supply monitor does not end wait.
- R7: can_wake on its own never ends a state. Together with an enabled synchronised pin, it is reported as cause 2 instead of cause 1.
- R8: In sleep, irq_pending ends the state on the next edge, and core_clk_en is 1 from the next cycle.
- R9: A wake pin counts only when its pin_en bit is 1. It passes two flip-flops, so a pin raised before edge n ends a state at edge n+2.
- R10: last_mode holds the cur_mode code of the last state entered. wake_cause holds the code of the event that ended the last state, using this priority: 2 CAN-through-pin, 1 pin, 3 supply monitor, 4 RTC, 5 RTT, 6 USB, 7 debug, 8 network, 9 interrupt. Both read 0 after reset.
- R11: sleep_req is ignored while the block is in any state other than run, including the restart and reset windows.
- R12: Elaboration rejects restart windows that exceed 10 µs (wait) or 2 ms (backup) at the CLK_KHZ clock, with the synchroniser delay included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request strobe from the core |
| cfg_deep_sleep | input | 1 | Deep-sleep bit |
| cfg_vreg_off | input | 1 | Regulator-off bit |
| cfg_wait_en | input | 1 | Wait-enable bit |
| cfg_lpm | input | 1 | Low-power bit |
| cfg_flash_lp | input | 1 | Flash state in wait: 1 deep power-down, 0 standby |
| cfg_mck_div | input | DIV_W | Master clock divider field |
| wake_pins | input | N_WAKE | Asynchronous wake pins |
| pin_en | input | N_WAKE | Per-pin wake enable |
| sup_mon_evt | input | 1 | Supply monitor event |
| rtc_alarm | input | 1 | RTC alarm |
| rtt_alarm | input | 1 | RTT alarm |
| usb_evt | input | 1 | High-speed USB wake event |
| dbg_pwrup_req | input | 1 | Debug power-up request |
| eth_wol_evt | input | 1 | Network wake packet event |
| can_wake | input | 1 | CAN wake indication |
| irq_pending | input | 1 | Any enabled interrupt pending |
| core_clk_en | output | 1 | Core clock enable |
| core_reg_en | output | 1 | Core regulator enable |
| flash_pwr | output | 2 | 0 on, 1 standby, 2 deep power-down, 3 off |
| core_rst_req | output | 1 | Core reset after backup wake |
| clk_on_rc | output | 1 | Clock resumed on the RC source after wait |
| cur_mode | output | 3 | 0 run, 1 sleep, 2 wait/standby, 3 wait/deep, 4 backup |
| last_mode | output | 3 | Last state entered |
| wake_cause | output | 4 | Event that ended the last state |

## Verification
State entry and the sleep exit show at the outputs one edge after the request or interrupt is sampled. Pin wakes arrive two edges later because of the synchroniser. The wait exit holds the clock off for WAIT_WAKE_CYC cycles after the wake edge, and the backup exit holds the reset for BKUP_RST_CYC cycles. The bench reference model advances on the same edges from the same sampled inputs, and all outputs are compared 3 ns after each rising edge. The directed checks count out these exact cycle numbers and sample at falling edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      MODE_RUN      = 3'd0,
      MODE_SLEEP    = 3'd1,
      MODE_WAIT_SB  = 3'd2,
      MODE_WAIT_DPD = 3'd3,
      MODE_BACKUP   = 3'd4
   } lpm_mode_e;

   typedef enum logic [2:0] {
      ST_RUN, ST_SLEEP, ST_WAIT, ST_BACKUP, ST_WAKEW, ST_BRST
   } seq_st_e;

   typedef enum logic [1:0] {
      CLS_NONE, CLS_SLEEP, CLS_WAIT, CLS_BACKUP
   } wake_cls_e;

   localparam logic [1:0] FL_ON   = 2'd0;
   localparam logic [1:0] FL_STBY = 2'd1;
   localparam logic [1:0] FL_DPD  = 2'd2;
   localparam logic [1:0] FL_OFF  = 2'd3;

   localparam logic [3:0] CAUSE_NONE = 4'd0;
   localparam logic [3:0] CAUSE_PIN  = 4'd1;
   localparam logic [3:0] CAUSE_CAN  = 4'd2;
   localparam logic [3:0] CAUSE_SUP  = 4'd3;
   localparam logic [3:0] CAUSE_RTC  = 4'd4;
   localparam logic [3:0] CAUSE_RTT  = 4'd5;
   localparam logic [3:0] CAUSE_USB  = 4'd6;
   localparam logic [3:0] CAUSE_DBG  = 4'd7;
   localparam logic [3:0] CAUSE_ETH  = 4'd8;
   localparam logic [3:0] CAUSE_IRQ  = 4'd9;

endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
   import lpm_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic             deep_sleep,
   input  logic             vreg_off,
   input  logic             wait_en,
   input  logic             lpm,
   input  logic             flash_lp,
   input  logic [DIV_W-1:0] mck_div,
   output logic             valid,
   output lpm_mode_e        mode
);

   initial begin
      assert (DIV_W >= 1) else $error("DIV_W must be at least 1");
   end

   always_comb begin
      valid = 1'b0;
      mode  = MODE_RUN;
      if (vreg_off && deep_sleep) begin
         valid = 1'b1;
         mode  = MODE_BACKUP;
      end else if (!deep_sleep && lpm && wait_en && (mck_div == '0)) begin
         valid = 1'b1;
         mode  = flash_lp ? MODE_WAIT_DPD : MODE_WAIT_SB;
      end else if (!deep_sleep && !lpm) begin
         valid = 1'b1;
         mode  = MODE_SLEEP;
      end
   end

endmodule

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
   parameter int N_WAKE = 14,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_WAKE-1:0] pins,
   input  logic [N_WAKE-1:0] en,
   output logic              pin_any
);

   initial begin
      assert (N_WAKE >= 1) else $error("N_WAKE must be at least 1");
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   logic [N_WAKE-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= pins & en;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[g] <= '0;
         else        chain[g] <= chain[g-1];
      end
   end

   assign pin_any = |chain[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      // R9: a synchronised pin must have been enabled and high two edges back
      p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pin_any) |-> $past(|(pins & en), 2));
   end

endmodule

// File: rtl/lpm_wake_select.sv
module lpm_wake_select
   import lpm_pkg::*;
(
   input  wake_cls_e   cls,
   input  logic        pin_any,
   input  logic        can_wake,
   input  logic        sup_mon,
   input  logic        rtc,
   input  logic        rtt,
   input  logic        usb,
   input  logic        dbg,
   input  logic        eth,
   input  logic        irq,
   output logic        hit,
   output logic [3:0]  cause
);

   logic [3:0] pin_code;
   assign pin_code = can_wake ? CAUSE_CAN : CAUSE_PIN;

   always_comb begin
      hit   = 1'b1;
      cause = CAUSE_NONE;
      unique case (cls)
         CLS_SLEEP: begin
            if (irq) cause = CAUSE_IRQ;
            else     hit   = 1'b0;
         end
         CLS_WAIT: begin
            if      (pin_any) cause = pin_code;
            else if (rtc)     cause = CAUSE_RTC;
            else if (rtt)     cause = CAUSE_RTT;
            else if (usb)     cause = CAUSE_USB;
            else if (dbg)     cause = CAUSE_DBG;
            else if (eth)     cause = CAUSE_ETH;
            else              hit   = 1'b0;
         end
         CLS_BACKUP: begin
            if      (pin_any) cause = CAUSE_PIN;
            else if (sup_mon) cause = CAUSE_SUP;
            else if (rtc)     cause = CAUSE_RTC;
            else if (rtt)     cause = CAUSE_RTT;
            else              hit   = 1'b0;
         end
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
   import lpm_pkg::*;
#(
   parameter int N_WAKE        = 14,
   parameter int DIV_W         = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int CLK_KHZ       = 12000,
   parameter int WAIT_WAKE_CYC = 8,
   parameter int BKUP_RST_CYC  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              cfg_deep_sleep,
   input  logic              cfg_vreg_off,
   input  logic              cfg_wait_en,
   input  logic              cfg_lpm,
   input  logic              cfg_flash_lp,
   input  logic [DIV_W-1:0]  cfg_mck_div,
   input  logic [N_WAKE-1:0] wake_pins,
   input  logic [N_WAKE-1:0] pin_en,
   input  logic              sup_mon_evt,
   input  logic              rtc_alarm,
   input  logic              rtt_alarm,
   input  logic              usb_evt,
   input  logic              dbg_pwrup_req,
   input  logic              eth_wol_evt,
   input  logic              can_wake,
   input  logic              irq_pending,
   output logic              core_clk_en,
   output logic              core_reg_en,
   output logic [1:0]        flash_pwr,
   output logic              core_rst_req,
   output logic              clk_on_rc,
   output logic [2:0]        cur_mode,
   output logic [2:0]        last_mode,
   output logic [3:0]        wake_cause
);

   localparam int WAIT_BUDGET = CLK_KHZ / 100;
   localparam int BKUP_BUDGET = CLK_KHZ * 2;
   localparam int CNT_MAX     = (WAIT_WAKE_CYC > BKUP_RST_CYC) ? WAIT_WAKE_CYC : BKUP_RST_CYC;
   localparam int CNT_W       = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_WAKE_CYC - 1);
   localparam logic [CNT_W-1:0] BKUP_LAST = CNT_W'(BKUP_RST_CYC - 1);

   // R12: restart windows fit the wakeup time limits
   initial begin
      assert (WAIT_WAKE_CYC >= 1 && BKUP_RST_CYC >= 1)
         else $error("restart windows must be at least one cycle");
      assert (WAIT_WAKE_CYC + SYNC_STAGES + 1 < WAIT_BUDGET)
         else $error("wait restart exceeds 10 us budget (R12)");
      assert (BKUP_RST_CYC + SYNC_STAGES + 1 < BKUP_BUDGET)
         else $error("backup restart exceeds 2 ms budget (R12)");
   end

   seq_st_e    st;
   lpm_mode_e  held;
   lpm_mode_e  last_q;
   logic [3:0] cause_q;
   logic [CNT_W-1:0] cnt;
   logic       rc_q;

   logic       dec_valid;
   lpm_mode_e  dec_mode;
   logic       pin_any;
   wake_cls_e  cls;
   logic       wake_hit;
   logic [3:0] wake_code;

   lpm_mode_decode #(.DIV_W(DIV_W)) u_dec (
      .deep_sleep (cfg_deep_sleep),
      .vreg_off   (cfg_vreg_off),
      .wait_en    (cfg_wait_en),
      .lpm        (cfg_lpm),
      .flash_lp   (cfg_flash_lp),
      .mck_div    (cfg_mck_div),
      .valid      (dec_valid),
      .mode       (dec_mode)
   );

   lpm_pin_sync #(.N_WAKE(N_WAKE), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (wake_pins),
      .en      (pin_en),
      .pin_any (pin_any)
   );

   always_comb begin
      case (st)
         ST_SLEEP:  cls = CLS_SLEEP;
         ST_WAIT:   cls = CLS_WAIT;
         ST_BACKUP: cls = CLS_BACKUP;
         default:   cls = CLS_NONE;
      endcase
   end

   lpm_wake_select u_sel (
      .cls      (cls),
      .pin_any  (pin_any),
      .can_wake (can_wake),
      .sup_mon  (sup_mon_evt),
      .rtc      (rtc_alarm),
      .rtt      (rtt_alarm),
      .usb      (usb_evt),
      .dbg      (dbg_pwrup_req),
      .eth      (eth_wol_evt),
      .irq      (irq_pending),
      .hit      (wake_hit),
      .cause    (wake_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_RUN;
         held    <= MODE_RUN;
         last_q  <= MODE_RUN;
         cause_q <= CAUSE_NONE;
         cnt     <= '0;
         rc_q    <= 1'b0;
      end else begin
         unique case (st)
            ST_RUN: if (sleep_req && dec_valid) begin
               held   <= dec_mode;
               last_q <= dec_mode;
               rc_q   <= 1'b0;
               if (dec_mode == MODE_BACKUP)     st <= ST_BACKUP;
               else if (dec_mode == MODE_SLEEP) st <= ST_SLEEP;
               else                             st <= ST_WAIT;
            end
            ST_SLEEP: if (wake_hit) begin
               st      <= ST_RUN;
               held    <= MODE_RUN;
               cause_q <= wake_code;
            end
            ST_WAIT: if (wake_hit) begin
               st      <= ST_WAKEW;
               cnt     <= '0;
               cause_q <= wake_code;
            end
            ST_WAKEW: if (cnt == WAIT_LAST) begin
               st   <= ST_RUN;
               held <= MODE_RUN;
               rc_q <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_BACKUP: if (wake_hit) begin
               st      <= ST_BRST;
               cnt     <= '0;
               cause_q <= wake_code;
            end
            ST_BRST: if (cnt == BKUP_LAST) begin
               st   <= ST_RUN;
               held <= MODE_RUN;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_WAIT:   flash_pwr = (held == MODE_WAIT_DPD) ? FL_DPD : FL_STBY;
         ST_BACKUP: flash_pwr = FL_OFF;
         default:   flash_pwr = FL_ON;
      endcase
   end

   assign core_clk_en  = (st == ST_RUN);
   assign core_reg_en  = (st != ST_BACKUP);
   assign core_rst_req = (st == ST_BRST);
   assign clk_on_rc    = rc_q;
   assign cur_mode     = held;
   assign last_mode    = last_q;
   assign wake_cause   = cause_q;

   // R1: backup entry removes regulator, clock and flash power
   p_backup_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_req && dec_valid && dec_mode == MODE_BACKUP)
      |=> (!core_reg_en && !core_clk_en && flash_pwr == FL_OFF));

   // R2: deep power-down flash follows a wait request with flash-low-power set
   p_wait_flash_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_req && dec_valid && dec_mode == MODE_WAIT_DPD)
      |=> (flash_pwr == FL_DPD && core_reg_en && !core_clk_en));

   // R3: sleep gates the clock only
   p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_req && dec_valid && dec_mode == MODE_SLEEP)
      |=> (!core_clk_en && core_reg_en && flash_pwr == FL_ON));

   // R4: refused requests leave the core running
   p_illegal_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_req && !dec_valid)
      |=> (core_clk_en && cur_mode == 3'(MODE_RUN)));

   // R5: backup exit goes through reset
   p_bkup_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BACKUP && wake_hit) |=> core_rst_req);

   // R6: wait exit never resets and keeps the clock off during restart
   p_wait_noreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && wake_hit) |=> (!core_rst_req && !core_clk_en));

   // R7: CAN indication alone keeps wait
   p_can_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && can_wake && !pin_any && !rtc_alarm && !rtt_alarm
       && !usb_evt && !dbg_pwrup_req && !eth_wol_evt) |=> (st == ST_WAIT));

   // R8: interrupt ends sleep on the next edge
   p_sleep_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP && irq_pending) |=> core_clk_en);

   // R11: requests outside run do not change the recorded mode
   p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_RUN && sleep_req) |=> $stable(last_mode));

endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;

   localparam int NW = 14;
   localparam int W  = 6;
   localparam int B  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, cfg_deep_sleep = 0, cfg_vreg_off = 0, cfg_wait_en = 0;
   logic cfg_lpm = 0, cfg_flash_lp = 0;
   logic [2:0] cfg_mck_div = '0;
   logic [NW-1:0] wake_pins = '0, pin_en = '0;
   logic sup_mon_evt = 0, rtc_alarm = 0, rtt_alarm = 0, usb_evt = 0;
   logic dbg_pwrup_req = 0, eth_wol_evt = 0, can_wake = 0, irq_pending = 0;
   logic core_clk_en, core_reg_en, core_rst_req, clk_on_rc;
   logic [1:0] flash_pwr;
   logic [2:0] cur_mode, last_mode;
   logic [3:0] wake_cause;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lpm_sequencer #(.N_WAKE(NW), .DIV_W(3), .SYNC_STAGES(2), .CLK_KHZ(12000),
                   .WAIT_WAKE_CYC(W), .BKUP_RST_CYC(B)) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
      .cfg_deep_sleep(cfg_deep_sleep), .cfg_vreg_off(cfg_vreg_off),
      .cfg_wait_en(cfg_wait_en), .cfg_lpm(cfg_lpm), .cfg_flash_lp(cfg_flash_lp),
      .cfg_mck_div(cfg_mck_div), .wake_pins(wake_pins), .pin_en(pin_en),
      .sup_mon_evt(sup_mon_evt), .rtc_alarm(rtc_alarm), .rtt_alarm(rtt_alarm),
      .usb_evt(usb_evt), .dbg_pwrup_req(dbg_pwrup_req), .eth_wol_evt(eth_wol_evt),
      .can_wake(can_wake), .irq_pending(irq_pending),
      .core_clk_en(core_clk_en), .core_reg_en(core_reg_en), .flash_pwr(flash_pwr),
      .core_rst_req(core_rst_req), .clk_on_rc(clk_on_rc), .cur_mode(cur_mode),
      .last_mode(last_mode), .wake_cause(wake_cause)
   );

   // Reference model: 0 run, 1 sleep, 2 wait, 3 backup, 4 restart, 5 reset hold
   int m_st = 0, m_mode = 0, m_last = 0, m_cause = 0, m_cnt = 0;
   bit m_rc = 0;
   logic [NW-1:0] m_s1 = '0, m_s2 = '0;

   always @(posedge clk) begin
      int req_mode;
      bit pin;
      int c;
      pin = (m_s2 != 0);
      if (!rst_n) begin
         m_st <= 0; m_mode <= 0; m_last <= 0; m_cause <= 0; m_cnt <= 0; m_rc <= 0;
         m_s1 <= '0; m_s2 <= '0;
      end else begin
         m_s1 <= wake_pins & pin_en;
         m_s2 <= m_s1;
         case (m_st)
            0: begin
               req_mode = -1;
               if (cfg_vreg_off && cfg_deep_sleep) req_mode = 4;
               else if (!cfg_deep_sleep && cfg_lpm && cfg_wait_en && cfg_mck_div == 0)
                  req_mode = cfg_flash_lp ? 3 : 2;
               else if (!cfg_deep_sleep && !cfg_lpm) req_mode = 1;
               if (sleep_req && req_mode >= 0) begin
                  m_mode <= req_mode; m_last <= req_mode; m_rc <= 0;
                  m_st <= (req_mode == 4) ? 3 : (req_mode == 1) ? 1 : 2;
               end
            end
            1: if (irq_pending) begin m_st <= 0; m_mode <= 0; m_cause <= 9; end
            2: begin
               c = 0;
               if (pin) c = can_wake ? 2 : 1;
               else if (rtc_alarm) c = 4;
               else if (rtt_alarm) c = 5;
               else if (usb_evt) c = 6;
               else if (dbg_pwrup_req) c = 7;
               else if (eth_wol_evt) c = 8;
               if (c != 0) begin m_st <= 4; m_cnt <= 0; m_cause <= c; end
            end
            3: begin
               c = 0;
               if (pin) c = 1;
               else if (sup_mon_evt) c = 3;
               else if (rtc_alarm) c = 4;
               else if (rtt_alarm) c = 5;
               if (c != 0) begin m_st <= 5; m_cnt <= 0; m_cause <= c; end
            end
            4: if (m_cnt == W - 1) begin m_st <= 0; m_mode <= 0; m_rc <= 1; end
               else m_cnt <= m_cnt + 1;
            5: if (m_cnt == B - 1) begin m_st <= 0; m_mode <= 0; end
               else m_cnt <= m_cnt + 1;
            default: m_st <= 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, 3 ns after each rising edge
   always @(posedge clk) begin
      int e_fl;
      #3;
      if (!done) begin
         e_fl = (m_st == 2) ? ((m_mode == 3) ? 2 : 1) : (m_st == 3) ? 3 : 0;
         chk(core_clk_en == (m_st == 0), "R3 core_clk_en", core_clk_en, m_st == 0);
         chk(core_reg_en == (m_st != 3), "R1 core_reg_en", core_reg_en, m_st != 3);
         chk(flash_pwr == e_fl, "R2 flash_pwr", flash_pwr, e_fl);
         chk(core_rst_req == (m_st == 5), "R5 core_rst_req", core_rst_req, m_st == 5);
         chk(clk_on_rc == m_rc, "R6 clk_on_rc", clk_on_rc, m_rc);
         chk(cur_mode == m_mode, "R4 cur_mode", cur_mode, m_mode);
         chk(last_mode == m_last, "R10 last_mode", last_mode, m_last);
         chk(wake_cause == m_cause, "R10 wake_cause", wake_cause, m_cause);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic cfg(input bit vo, input bit ds, input bit we, input bit lp,
                      input bit fl, input int dv);
      cfg_vreg_off = vo; cfg_deep_sleep = ds; cfg_wait_en = we;
      cfg_lpm = lp; cfg_flash_lp = fl; cfg_mck_div = 3'(dv);
   endtask

   task automatic request();
      @(negedge clk) sleep_req = 1;
      @(negedge clk) sleep_req = 0;
   endtask

   // 1 sup, 2 rtc, 3 rtt, 4 usb, 5 dbg, 6 eth, 7 can, 8 irq
   task automatic fire(input int which);
      @(negedge clk);
      case (which)
         1: sup_mon_evt = 1;   2: rtc_alarm = 1;     3: rtt_alarm = 1;
         4: usb_evt = 1;       5: dbg_pwrup_req = 1; 6: eth_wol_evt = 1;
         7: can_wake = 1;      default: irq_pending = 1;
      endcase
      @(negedge clk);
      {sup_mon_evt, rtc_alarm, rtt_alarm, usb_evt, dbg_pwrup_req,
       eth_wol_evt, can_wake, irq_pending} = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_wake_check(input int src, input int exp_cause);
      fire(src);
      chk(!core_clk_en && !core_rst_req, "R6 restart clock off", core_clk_en, 0);
      for (int i = 0; i < W - 1; i++) begin
         @(negedge clk);
         chk(!core_clk_en && !core_rst_req, "R6 restart window", core_clk_en, 0);
      end
      @(negedge clk);
      chk(core_clk_en == 1, "R6 resume", core_clk_en, 1);
      chk(clk_on_rc == 1, "R6 rc source", clk_on_rc, 1);
      chk(wake_cause == exp_cause, "R10 wait cause", wake_cause, exp_cause);
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      chk(last_mode == 0 && wake_cause == 0 && core_clk_en, "R10 reset", last_mode, 0);

      // sleep entry and exit
      cfg(0, 0, 0, 0, 0, 0);
      request();
      chk(cur_mode == 1 && !core_clk_en && core_reg_en, "R3 sleep", cur_mode, 1);
      cfg(1, 1, 0, 0, 0, 0);
      request();
      chk(last_mode == 1 && cur_mode == 1, "R11 busy request", last_mode, 1);
      cfg(0, 0, 0, 0, 0, 0);
      fire(4);
      chk(cur_mode == 1, "R8 usb ignored in sleep", cur_mode, 1);
      fire(8);
      chk(core_clk_en == 1, "R8 irq wake", core_clk_en, 1);
      chk(wake_cause == 9, "R10 irq cause", wake_cause, 9);

      // refused combinations
      cfg(0, 1, 0, 0, 0, 0); request();
      chk(cur_mode == 0 && core_clk_en, "R4 deep without vreg_off", cur_mode, 0);
      cfg(0, 0, 0, 1, 0, 0); request();
      chk(cur_mode == 0, "R4 lpm without wait_en", cur_mode, 0);
      cfg(0, 0, 1, 1, 0, 2); request();
      chk(cur_mode == 0, "R4 nonzero divider", cur_mode, 0);

      // wait with flash standby
      cfg(0, 0, 1, 1, 0, 0); request();
      chk(cur_mode == 2 && flash_pwr == 1, "R2 standby flash", flash_pwr, 1);
      fire(1); idle(2);
      chk(cur_mode == 2 && !core_clk_en, "R6 supply monitor ignored", cur_mode, 2);
      wait_wake_check(2, 4);

      // wait with flash deep power-down
      cfg(0, 0, 1, 1, 1, 0); request();
      chk(cur_mode == 3 && flash_pwr == 2, "R2 deep flash", flash_pwr, 2);
      chk(clk_on_rc == 0, "R6 rc cleared on entry", clk_on_rc, 0);
      @(negedge clk) can_wake = 1;
      idle(4);
      can_wake = 0;
      chk(cur_mode == 3 && !core_clk_en, "R7 can alone", cur_mode, 3);
      wake_pins[5] = 1; idle(4); wake_pins[5] = 0; idle(2);
      chk(cur_mode == 3 && !core_clk_en, "R9 disabled pin", cur_mode, 3);
      pin_en[5] = 1;
      @(negedge clk); wake_pins[5] = 1; can_wake = 1;
      @(negedge clk);
      @(negedge clk);
      chk(wake_cause == 4, "R9 two-stage delay", wake_cause, 4);
      @(negedge clk);
      chk(wake_cause == 2, "R7 can through pin", wake_cause, 2);
      wake_pins[5] = 0; can_wake = 0;
      idle(W + 1);
      chk(core_clk_en == 1, "R6 pin resume", core_clk_en, 1);

      // remaining wait sources
      cfg(0, 0, 1, 1, 0, 0); request(); wait_wake_check(3, 5);
      request(); wait_wake_check(4, 6);
      request(); wait_wake_check(5, 7);
      request(); wait_wake_check(6, 8);

      // backup
      cfg(1, 1, 0, 0, 0, 0); request();
      chk(!core_reg_en && flash_pwr == 3 && cur_mode == 4, "R1 backup", core_reg_en, 0);
      fire(8); fire(4); fire(5); fire(6); idle(1);
      chk(cur_mode == 4 && !core_rst_req, "R5 ignored sources", cur_mode, 4);
      fire(1);
      chk(core_rst_req == 1, "R5 reset asserted", core_rst_req, 1);
      chk(wake_cause == 3, "R10 supply cause", wake_cause, 3);
      idle(B);
      chk(core_clk_en && !core_rst_req && clk_on_rc == 0, "R5 run after reset", core_clk_en, 1);
      pin_en = '0; pin_en[13] = 1;
      request();
      @(negedge clk) wake_pins[13] = 1;
      idle(3);
      wake_pins[13] = 0;
      chk(core_rst_req == 1 && wake_cause == 1, "R5 pin wake", wake_cause, 1);
      idle(B + 2);
      chk(core_clk_en == 1, "R5 backup done", core_clk_en, 1);

      idle(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule